// File: doc/BRIEF.md
# Receive Frame Statistics Counter Bank

This block keeps the receive-side statistics of a network port. For every frame that the receive path accepts, the block gets a one-cycle strobe. With the strobe come two lengths: the payload length and the full on-wire length, which includes the frame check sequence. From these the block does three things:

- It sorts the frame into one of six size bins, using the full length.
- It counts the frame in a total-frames counter.
- It adds the payload length plus a fixed 4-byte check-sequence allowance to a 64-bit octet total.

A "good frames" view and a "good octets" view mirror the totals. No counter wraps. Each one holds at its all-ones value once it gets there. A synchronous clear input sets the whole bank back to zero.

Software or a neighbouring block reads the counters through a combinational register read port. The port returns one counter word for each address.

Top module: `rx_stat_bank`

## Requirements
- R1: The length that includes the check sequence picks one size bin. Bins and read addresses:
  - exactly 64 bytes: address 0
  - 65 to 127: address 1
  - 128 to 255: address 2
  - 256 to 511: address 3
  - 512 to 1023: address 4
  - 1024 and above: address 5
- R2: A frame whose full length is below 64 bytes increments no size bin. It still increments the total-frames counter, which reads at address 6.
- R3: Every frame and bin counter holds at its all-ones value instead of wrapping.
- R4: For each frame, the octet total grows by payload length plus 4. The octet total is twice the counter width wide. Its low word reads at address 8 and its high word at address 9.
- R5: The octet total clamps to all ones when an addition would overflow it.
- R6: Three addresses mirror the totals:
  - address 7 (good frames) always equals address 6
  - address 10 always equals address 8
  - address 11 always equals address 9
- R7: Counters change on the clock edge that samples the strobe. A read made in the strobe's cycle returns the value from before the update.
- R8: A synchronous clear zeroes every counter. A clear wins over a strobe in the same cycle.
- R9: After reset every counter reads zero. Addresses 12 and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all counters |
| frm_vld | input | 1 | One-cycle strobe per accepted frame |
| pay_len | input | LEN_W | Payload length in bytes, without the check sequence |
| tot_len | input | LEN_W | Frame length in bytes, with the check sequence |
| rd_addr | input | 4 | Counter word select |
| rd_data | output | CNT_W | Selected counter word (combinational) |

## Verification
Random payload lengths over the whole range, combined with full lengths below 64, separate random traffic from the size-sorting and octet logic. Directed lengths on each side of every bin edge (63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024) tell apart off-by-one errors in the comparisons. A second instance with narrow counters gets a long run of large frames, which drives the frame, bin and octet counters into saturation and separates clamping from wrapping. Directed strobe-and-read and clear-with-strobe cycles tell apart the update timing and the clear priority.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int NUM_BINS = 6;
    localparam int NUM_WORDS = 12;
    localparam int ADDR_W = 4;
    localparam int FCS_BYTES = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_B64    = 4'd0,
        SEL_B127   = 4'd1,
        SEL_B255   = 4'd2,
        SEL_B511   = 4'd3,
        SEL_B1023  = 4'd4,
        SEL_BMAX   = 4'd5,
        SEL_FRM    = 4'd6,
        SEL_GFRM   = 4'd7,
        SEL_OCTL   = 4'd8,
        SEL_OCTH   = 4'd9,
        SEL_GOCTL  = 4'd10,
        SEL_GOCTH  = 4'd11
    } rd_sel_e;

    // One-hot size bin for a full frame length; zero when below 64 bytes.
    function automatic logic [NUM_BINS-1:0] bin_onehot(input logic [31:0] len);
        logic [NUM_BINS-1:0] h;
        h = '0;
        if (len >= 32'd1024)      h[5] = 1'b1;
        else if (len >= 32'd512)  h[4] = 1'b1;
        else if (len >= 32'd256)  h[3] = 1'b1;
        else if (len >= 32'd128)  h[2] = 1'b1;
        else if (len >= 32'd65)   h[1] = 1'b1;
        else if (len == 32'd64)   h[0] = 1'b1;
        return h;
    endfunction

endpackage

// File: rtl/rxs_sat_cnt.sv
module rxs_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc && q != MAXV) begin
            q <= q + 1'b1;
        end
    end

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (q == MAXV && !clr) |=> q == MAXV);

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && q != MAXV) |=> q == $past(q) + 1'b1);

endmodule

// File: rtl/rxs_oct_acc.sv
module rxs_oct_acc #(
    parameter int W  = 64,
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [AW-1:0] add,
    output logic [W-1:0]  acc
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, acc} + (W+1)'(add);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= sum[W] ? MAXV : sum[W-1:0];
        end
    end

    p_oct_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        (acc == MAXV && !clr) |=> acc == MAXV);

    p_oct_mono_r4: assert property (@(posedge clk) disable iff (rst)
        !clr |=> acc >= $past(acc));

endmodule

// File: rtl/rxs_rd_mux.sv
module rxs_rd_mux #(
    parameter int W  = 32,
    parameter int N  = 12,
    parameter int AW = 4
) (
    input  logic [AW-1:0]  addr,
    input  logic [N*W-1:0] words,
    output logic [W-1:0]   data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < N; i++) begin
            if (int'(addr) == i) data = words[i*W +: W];
        end
    end
endmodule

// File: rtl/rx_stat_bank.sv
module rx_stat_bank
    import rxs_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              frm_vld,
    input  logic [LEN_W-1:0]  pay_len,
    input  logic [LEN_W-1:0]  tot_len,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    localparam int OCT_W = 2 * CNT_W;
    localparam int ADD_W = LEN_W + 1;

    logic [NUM_BINS-1:0]       bin_hit;
    logic [NUM_BINS*CNT_W-1:0] bin_flat;
    logic [CNT_W-1:0]          frm_q;
    logic [OCT_W-1:0]          oct_q;
    logic [ADD_W-1:0]          oct_add;
    logic [NUM_WORDS*CNT_W-1:0] words;

    assign bin_hit = frm_vld ? bin_onehot(32'(tot_len)) : '0;
    assign oct_add = ADD_W'(pay_len) + ADD_W'(FCS_BYTES);

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
        rxs_sat_cnt #(.W(CNT_W)) u_bin (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .inc (bin_hit[g]),
            .q   (bin_flat[g*CNT_W +: CNT_W])
        );
    end

    rxs_sat_cnt #(.W(CNT_W)) u_frm (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .inc (frm_vld),
        .q   (frm_q)
    );

    rxs_oct_acc #(.W(OCT_W), .AW(ADD_W)) u_oct (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .en  (frm_vld),
        .add (oct_add),
        .acc (oct_q)
    );

    assign words[NUM_BINS*CNT_W-1:0]                      = bin_flat;
    assign words[int'(SEL_FRM)*CNT_W   +: CNT_W]          = frm_q;
    assign words[int'(SEL_GFRM)*CNT_W  +: CNT_W]          = frm_q;
    assign words[int'(SEL_OCTL)*CNT_W  +: CNT_W]          = oct_q[CNT_W-1:0];
    assign words[int'(SEL_OCTH)*CNT_W  +: CNT_W]          = oct_q[OCT_W-1:CNT_W];
    assign words[int'(SEL_GOCTL)*CNT_W +: CNT_W]          = oct_q[CNT_W-1:0];
    assign words[int'(SEL_GOCTH)*CNT_W +: CNT_W]          = oct_q[OCT_W-1:CNT_W];

    rxs_rd_mux #(.W(CNT_W), .N(NUM_WORDS), .AW(ADDR_W)) u_rd (
        .addr  (rd_addr),
        .words (words),
        .data  (rd_data)
    );

    p_bin_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bin_hit));

    p_small_skip_r2: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && tot_len < LEN_W'(64) && !clr) |=> $stable(bin_flat));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (frm_q == '0 && oct_q == '0 && bin_flat == '0));

endmodule

// File: tb/tb_rx_stat_bank.sv
`timescale 1ns/1ps
module tb_rx_stat_bank;

    logic        clk = 1'b0;
    logic        rst, clr, frm_vld;
    logic [15:0] pay_len, tot_len;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;

    logic        s_clr, s_vld;
    logic [15:0] s_pay, s_tot;
    logic [3:0]  s_addr;
    logic [7:0]  s_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_stat_bank #(.CNT_W(32), .LEN_W(16)) dut (
        .clk(clk), .rst(rst), .clr(clr), .frm_vld(frm_vld),
        .pay_len(pay_len), .tot_len(tot_len), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    rx_stat_bank #(.CNT_W(8), .LEN_W(16)) dut_small (
        .clk(clk), .rst(rst), .clr(s_clr), .frm_vld(s_vld),
        .pay_len(s_pay), .tot_len(s_tot), .rd_addr(s_addr), .rd_data(s_data)
    );

    // reference model of the 32-bit instance
    logic [31:0] m_bin [6];
    logic [31:0] m_frm;
    logic [63:0] m_oct;

    function automatic int bin_idx(input int t);
        if (t < 64)   return -1;
        if (t == 64)  return 0;
        if (t < 128)  return 1;
        if (t < 256)  return 2;
        if (t < 512)  return 3;
        if (t < 1024) return 4;
        return 5;
    endfunction

    function automatic logic [31:0] sinc32(input logic [31:0] v);
        return (v == 32'hFFFF_FFFF) ? v : v + 32'd1;
    endfunction

    function automatic logic [63:0] sadd64(input logic [63:0] v, input int a);
        logic [64:0] s;
        s = {1'b0, v} + 65'(a);
        return s[64] ? 64'hFFFF_FFFF_FFFF_FFFF : s[63:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        rd_addr = 4'(a);
        #0.5;
        v = rd_data;
    endtask

    task automatic model_clear();
        for (int i = 0; i < 6; i++) m_bin[i] = '0;
        m_frm = '0;
        m_oct = '0;
    endtask

    task automatic send(input int pay, input int tot);
        int b;
        @(negedge clk);
        frm_vld = 1'b1; pay_len = 16'(pay); tot_len = 16'(tot);
        b = bin_idx(tot);
        if (b >= 0) m_bin[b] = sinc32(m_bin[b]);
        m_frm = sinc32(m_frm);
        m_oct = sadd64(m_oct, pay + 4);
        @(negedge clk);
        frm_vld = 1'b0;
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] v;
        for (int i = 0; i < 6; i++) begin
            rd(i, v); chk({"R1 bin ", ctx}, 64'(v), 64'(m_bin[i]));
        end
        rd(6, v);  chk({"R2 total frames ", ctx}, 64'(v), 64'(m_frm));
        rd(7, v);  chk({"R6 good frames ", ctx}, 64'(v), 64'(m_frm));
        rd(8, v);  chk({"R4 octets low ", ctx}, 64'(v), 64'(m_oct[31:0]));
        rd(9, v);  chk({"R4 octets high ", ctx}, 64'(v), 64'(m_oct[63:32]));
        rd(10, v); chk({"R6 good octets low ", ctx}, 64'(v), 64'(m_oct[31:0]));
        rd(11, v); chk({"R6 good octets high ", ctx}, 64'(v), 64'(m_oct[63:32]));
        for (int i = 12; i < 16; i++) begin
            rd(i, v); chk({"R9 unmapped ", ctx}, 64'(v), 64'd0);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, old;
        logic [7:0]  sv;
        int p;
        void'($urandom(32'd20240517));
        rst = 1'b1; clr = 1'b0; frm_vld = 1'b0; pay_len = '0; tot_len = '0; rd_addr = '0;
        s_clr = 1'b0; s_vld = 1'b0; s_pay = '0; s_tot = '0; s_addr = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("after reset R9");

        // directed bin boundaries (R1, R2)
        send(59, 63);
        check_all("len 63 R2");
        send(60, 64);   send(61, 65);   send(123, 127); send(124, 128);
        send(251, 255); send(252, 256); send(507, 511); send(508, 512);
        send(1019, 1023); send(1020, 1024); send(0, 0); send(9000, 9004);
        check_all("edges R1");

        // strobe timing R7
        @(negedge clk);
        rd(6, old);
        frm_vld = 1'b1; pay_len = 16'd100; tot_len = 16'd104;
        rd(6, v);
        chk("R7 read during strobe", 64'(v), 64'(old));
        m_frm = sinc32(m_frm); m_bin[1] = sinc32(m_bin[1]); m_oct = sadd64(m_oct, 104);
        @(negedge clk);
        frm_vld = 1'b0;
        rd(6, v);
        chk("R7 read after edge", 64'(v), 64'(sinc32(old)));

        // random traffic
        for (int k = 0; k < 400; k++) begin
            if (($urandom % 5) == 0) p = $urandom_range(0, 59);
            else p = $urandom_range(0, 1600);
            send(p, p + 4);
        end
        check_all("random");

        // clear with simultaneous strobe R8
        @(negedge clk);
        clr = 1'b1; frm_vld = 1'b1; pay_len = 16'd500; tot_len = 16'd504;
        @(negedge clk);
        clr = 1'b0; frm_vld = 1'b0;
        model_clear();
        check_all("clear R8");
        send(60, 64);
        check_all("after clear R8");

        // saturation on narrow instance R3 R5
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            s_vld = 1'b1; s_pay = 16'd1496; s_tot = 16'd1500;
        end
        @(negedge clk);
        s_vld = 1'b0;
        s_addr = 4'd6;  #0.5; sv = s_data; chk("R3 frames saturate", 64'(sv), 64'hFF);
        s_addr = 4'd5;  #0.5; sv = s_data; chk("R3 bin saturate", 64'(sv), 64'hFF);
        s_addr = 4'd1;  #0.5; sv = s_data; chk("R3 other bin untouched", 64'(sv), 64'h0);
        s_addr = 4'd8;  #0.5; sv = s_data; chk("R5 octets low clamp", 64'(sv), 64'hFF);
        s_addr = 4'd9;  #0.5; sv = s_data; chk("R5 octets high clamp", 64'(sv), 64'hFF);
        s_addr = 4'd11; #0.5; sv = s_data; chk("R6 good octets high clamp", 64'(sv), 64'hFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule